// File: doc/BRIEF.md
# ADC Channel-List Acquisition Controller

This block sits between a 16-bit register bus and a 12-bit sampling converter that has 16 inputs. Software loads a channel list, where each byte chooses an input, a gain code, a polarity and single-ended or differential wiring. It then picks software-trigger mode. After that, every read of the start address launches one conversion of the next list entry. The list is walked cyclically and wraps back to its first entry after the last one written.

Each result is stored with its most significant bit flipped, so software recovers offset binary with an XOR of 0x800. Results queue in a sample FIFO that software drains through one read address. A status word reports the fill state of both FIFOs and whether a conversion is in flight. A half-full interrupt is latched as a pending flag and gated onto the interrupt pin by a global enable. Clearing either enable bit in the second control word flushes the FIFO that bit guards.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status word reads 0x0004 (sample FIFO empty), the interrupt pin is low, no conversion is started and a sample read returns 0.
- R2: A byte written at offset 0x10 is one list entry: bits 3:0 give the channel, bits 5:4 the gain code, bit 6 selects unipolar and bit 7 selects differential. During the conversion of that entry these fields appear on adc_chan, adc_gain, adc_unipolar and adc_diff.
- R3: With control word 1 (offset 0x00) bits 1:0 equal to 1, a read of offset 0x00 pulses adc_start for one cycle. Status bit 0 then stays high for CONV_CYCLES cycles, after which adc_data is captured and queued.
- R4: A start read is ignored when the mode is 0, 2 or 3, while a conversion is busy, or while the channel list is empty.
- R5: Successive start reads convert list entries in write order and wrap to the first entry after the last one written.
- R6: A read of offset 0x10 pops the oldest sample and returns it as {4'b0, captured_data XOR 0x800}.
- R7: A read of an empty sample FIFO returns the last value popped, leaves the FIFO empty, and later samples read back correctly.
- R8: Status (offset 0x04 read) has bit 4 full (16 samples), bit 3 half full (8 or more), bit 2 empty, bit 1 list full (16 entries), bit 0 busy and bit 8 half-full interrupt pending.
- R9: While control word 2 (offset 0x02) bit 10 is 0 the sample FIFO is held empty and results are dropped. While bit 9 is 0 the channel list is held empty and list writes are dropped.
- R10: A list write while the list holds 16 entries is ignored.
- R11: A result that completes while the sample FIFO holds 16 samples is dropped and the count stays at 16.
- R12: When the half-full flag rises and control word 1 bit 8 is set, the pending flag is set. The interrupt pin follows pending AND control word 1 bit 15. Any write to offset 0x04 clears pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| adc_start | output | 1 | One-cycle convert pulse |
| adc_chan | output | 4 | Channel of the entry being converted |
| adc_gain | output | 2 | Gain code of that entry |
| adc_unipolar | output | 1 | Unipolar select of that entry |
| adc_diff | output | 1 | Differential select of that entry |
| adc_data | input | SMP_W | Converter result, captured at end of conversion |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- neither FIFO exceeds its depth, and a full FIFO refuses a push;
- a pop of an empty FIFO leaves it empty;
- the list scan pointer stays inside the written entries;
- a start pulse only follows software-trigger mode and never lands on a busy converter;
- a disabled sample FIFO is empty one cycle later;
- a clear write drops the pending flag.

The bench scenarios are the only way to show the rest: the entry field mapping on the converter pins, the MSB inversion, the cyclic list order with its wrap after a full list, the last-value return on empty reads, dropping at full, and the interrupt gating by the global enable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int BUS_W = 16;

  // byte offsets
  localparam int OFS_CTRL1 = 'h00;  // write: control 1, read: start conversion
  localparam int OFS_CTRL2 = 'h02;  // write: control 2
  localparam int OFS_STAT  = 'h04;  // read: status, write: clear pending
  localparam int OFS_LIST  = 'h10;  // write: list entry, read: sample pop

  // control 1 bits
  localparam int C1_HIRQ_EN = 8;
  localparam int C1_GIRQ_EN = 15;
  // control 2 bits
  localparam int C2_LIST_EN = 9;
  localparam int C2_SMP_EN  = 10;
  // status bits
  localparam int ST_BUSY  = 0;
  localparam int ST_LFULL = 1;
  localparam int ST_EMPTY = 2;
  localparam int ST_HALF  = 3;
  localparam int ST_FULL  = 4;
  localparam int ST_PEND  = 8;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_SCAN = 2'd2,
    MODE_EXT  = 2'd3
  } acq_mode_e;

  typedef struct packed {
    logic       diff;
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] chan;
  } list_entry_t;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr_q];
  assign count   = count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R11
  fifo_cap_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/chan_list.sv
module chan_list #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         adv,
  output logic [W-1:0] entry,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count_q;
  logic [AW-1:0] scan_q;
  logic          do_wr;

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
  assign do_wr = wr && !full && !clr;
  assign entry = mem[scan_q];

  always_ff @(posedge clk) begin
    if (do_wr) mem[count_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
      scan_q  <= '0;
    end else begin
      if (do_wr) count_q <= count_q + CW'(1);
      if (adv && !empty)
        scan_q <= (CW'(scan_q) + CW'(1) == count_q) ? '0 : scan_q + AW'(1);
    end
  end

  // R5
  scan_range_chk: assert property (@(posedge clk) disable iff (rst)
    !empty |-> (CW'(scan_q) < count_q));
  // R10
  list_full_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr && !clr) |=> full);
  // R10
  list_cap_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/conv_engine.sv
module conv_engine #(
  parameter int SMP_W       = 12,
  parameter int ENTRY_W     = 8,
  parameter int CONV_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [ENTRY_W-1:0] entry_in,
  input  logic [SMP_W-1:0]   adc_data,
  output logic               adc_start,
  output logic [ENTRY_W-1:0] entry_out,
  output logic               busy,
  output logic               res_valid,
  output logic [SMP_W-1:0]   res
);
  localparam int CNT_W = $clog2(CONV_CYCLES+1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      adc_start <= 1'b0;
      res_valid <= 1'b0;
      res       <= '0;
      entry_out <= '0;
    end else begin
      adc_start <= 1'b0;
      res_valid <= 1'b0;
      if (launch && !busy) begin
        busy      <= 1'b1;
        cnt_q     <= CNT_W'(CONV_CYCLES-1);
        entry_out <= entry_in;
        adc_start <= 1'b1;
      end else if (busy) begin
        if (cnt_q == '0) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res       <= adc_data;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  // R4
  no_relaunch_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !launch);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> busy);
  // R3
  done_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(busy) && !busy));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SMP_W       = 12,
  parameter int SMP_DEPTH   = 16,
  parameter int LIST_DEPTH  = 16,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              adc_start,
  output logic [3:0]        adc_chan,
  output logic [1:0]        adc_gain,
  output logic              adc_unipolar,
  output logic              adc_diff,
  input  logic [SMP_W-1:0]  adc_data,
  output logic              irq
);
  localparam int ENTRY_W = $bits(list_entry_t);
  localparam int SCW     = $clog2(SMP_DEPTH+1);
  localparam int HALF    = SMP_DEPTH / 2;
  localparam int PAD_W   = BUS_W - SMP_W;

  acq_mode_e        mode_q;
  logic             hirq_en_q, girq_en_q, smp_en_q, list_en_q;
  logic             pend_q, half_d_q, irq_q;
  logic [BUS_W-1:0] rdata_q, status;
  logic [SMP_W-1:0] last_q;

  logic hit_c1, hit_c2, hit_st, hit_ls;
  assign hit_c1 = (bus_addr == ADDR_W'(OFS_CTRL1));
  assign hit_c2 = (bus_addr == ADDR_W'(OFS_CTRL2));
  assign hit_st = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_ls = (bus_addr == ADDR_W'(OFS_LIST));

  logic unused_bits;
  assign unused_bits = ^bus_wdata[14:11];

  // channel list
  logic               l_full, l_empty, launch;
  logic [ENTRY_W-1:0] l_entry;
  chan_list #(.W(ENTRY_W), .DEPTH(LIST_DEPTH)) list_i (
    .clk(clk), .rst(rst), .clr(!list_en_q),
    .wr(bus_wr && hit_ls), .din(bus_wdata[ENTRY_W-1:0]),
    .adv(launch), .entry(l_entry), .full(l_full), .empty(l_empty)
  );

  // converter sequencing
  logic               busy, res_valid;
  logic [SMP_W-1:0]   res;
  logic [ENTRY_W-1:0] cur_entry;
  list_entry_t        cur_f;
  assign launch = bus_rd && hit_c1 && (mode_q == MODE_SOFT) && !busy && !l_empty;

  conv_engine #(.SMP_W(SMP_W), .ENTRY_W(ENTRY_W), .CONV_CYCLES(CONV_CYCLES)) conv_i (
    .clk(clk), .rst(rst), .launch(launch), .entry_in(l_entry),
    .adc_data(adc_data), .adc_start(adc_start), .entry_out(cur_entry),
    .busy(busy), .res_valid(res_valid), .res(res)
  );

  assign cur_f        = list_entry_t'(cur_entry);
  assign adc_chan     = cur_f.chan;
  assign adc_gain     = cur_f.gain;
  assign adc_unipolar = cur_f.unipolar;
  assign adc_diff     = cur_f.diff;

  // sample FIFO, stored with inverted MSB
  logic             s_full, s_empty, s_pop, half;
  logic [SMP_W-1:0] s_dout, s_din;
  logic [SCW-1:0]   s_count;
  assign s_din = {~res[SMP_W-1], res[SMP_W-2:0]};
  assign s_pop = bus_rd && hit_ls;

  sample_fifo #(.W(SMP_W), .DEPTH(SMP_DEPTH)) smp_i (
    .clk(clk), .rst(rst), .clr(!smp_en_q),
    .push(res_valid), .din(s_din), .pop(s_pop),
    .dout(s_dout), .count(s_count), .full(s_full), .empty(s_empty)
  );
  assign half = (s_count >= SCW'(HALF));

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_OFF;
      hirq_en_q <= 1'b0;
      girq_en_q <= 1'b0;
      smp_en_q  <= 1'b0;
      list_en_q <= 1'b0;
    end else if (bus_wr) begin
      if (hit_c1) begin
        mode_q    <= acq_mode_e'(bus_wdata[1:0]);
        hirq_en_q <= bus_wdata[C1_HIRQ_EN];
        girq_en_q <= bus_wdata[C1_GIRQ_EN];
      end
      if (hit_c2) begin
        smp_en_q  <= bus_wdata[C2_SMP_EN];
        list_en_q <= bus_wdata[C2_LIST_EN];
      end
    end
  end

  // interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      half_d_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      half_d_q <= half;
      if (half && !half_d_q && hirq_en_q) pend_q <= 1'b1;
      else if (bus_wr && hit_st)          pend_q <= 1'b0;
      irq_q <= pend_q && girq_en_q;
    end
  end
  assign irq = irq_q;

  // status and read data
  always_comb begin
    status           = '0;
    status[ST_BUSY]  = busy;
    status[ST_LFULL] = l_full;
    status[ST_EMPTY] = s_empty;
    status[ST_HALF]  = half;
    status[ST_FULL]  = s_full;
    status[ST_PEND]  = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      last_q  <= '0;
    end else if (bus_rd) begin
      if (hit_st) begin
        rdata_q <= status;
      end else if (hit_ls) begin
        if (!s_empty) begin
          rdata_q <= {{PAD_W{1'b0}}, s_dout};
          last_q  <= s_dout;
        end else begin
          rdata_q <= {{PAD_W{1'b0}}, last_q};
        end
      end else begin
        rdata_q <= '0;
      end
    end
  end
  assign bus_rdata = rdata_q;

  // R12
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_st && !(half && !half_d_q)) |=> !pend_q);
  // R9
  smp_flush_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_en_q |=> s_empty);
  // R4
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $past(mode_q == MODE_SOFT));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int CONV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        adc_start, adc_unipolar, adc_diff, irq;
  logic [3:0]  adc_chan;
  logic [1:0]  adc_gain;
  logic [11:0] adc_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // converter model: result is a fixed function of the entry being converted
  assign adc_data = {adc_chan, adc_gain, adc_unipolar, adc_diff, 4'h3};

  adc_seq_ctrl #(.CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_gain(adc_gain),
    .adc_unipolar(adc_unipolar), .adc_diff(adc_diff),
    .adc_data(adc_data), .irq(irq)
  );

  function automatic logic [15:0] smp_of(input logic [7:0] e);
    return {4'h0, {e[3:0], e[5:4], e[6], e[7], 4'h3} ^ 12'h800};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert();
    logic [15:0] d;
    rd(5'h00, d);
    idle(CONV + 4);
  endtask

  task automatic fresh(input logic [15:0] c1);
    wr(5'h00, 16'h0000);
    wr(5'h02, 16'h0000);
    wr(5'h02, 16'h0600);
    wr(5'h04, 16'h0000);
    wr(5'h00, c1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 start", {15'b0, adc_start}, 16'h0);
    rd(5'h04, d); chk("R1 status", d, 16'h0004);
    rd(5'h10, d); chk("R1 sample", d, 16'h0000);
  endtask

  task automatic t_format();
    logic [15:0] d;
    fresh(16'h0001);
    wr(5'h10, 16'h00A5);
    rd(5'h00, d);
    chk("R3 start pulse", {15'b0, adc_start}, 16'h1);
    chk("R2 fields", {8'h0, adc_diff, adc_unipolar, adc_gain, adc_chan}, 16'h00A5);
    rd(5'h04, d); chk("R3 busy", d & 16'h0001, 16'h0001);
    chk("R3 pulse ends", {15'b0, adc_start}, 16'h0);
    idle(CONV + 4);
    rd(5'h04, d); chk("R3 done", d, 16'h0000);
    rd(5'h10, d); chk("R6 sample", d, smp_of(8'hA5));
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    fresh(16'h0002);
    wr(5'h10, 16'h0011);
    convert(); rd(5'h04, d); chk("R4 scan mode", d, 16'h0004);
    wr(5'h00, 16'h0000);
    convert(); rd(5'h04, d); chk("R4 off mode", d, 16'h0004);
    wr(5'h00, 16'h0003);
    convert(); rd(5'h04, d); chk("R4 ext mode", d, 16'h0004);
    wr(5'h00, 16'h0001);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 5'h00;
    @(negedge clk);
    @(negedge clk); bus_rd = 1'b0;
    idle(CONV + 4);
    rd(5'h10, d); chk("R4 busy first", d, smp_of(8'h11));
    rd(5'h04, d); chk("R4 busy ignored", d, 16'h0004);
    wr(5'h02, 16'h0400);
    convert(); rd(5'h04, d); chk("R4 empty list", d, 16'h0004);
  endtask

  task automatic t_cycle();
    logic [15:0] d;
    logic [7:0]  e [3] = '{8'h12, 8'h5C, 8'hE7};
    fresh(16'h0001);
    for (int i = 0; i < 3; i++) wr(5'h10, {8'h0, e[i]});
    for (int i = 0; i < 4; i++) convert();
    for (int i = 0; i < 4; i++) begin
      rd(5'h10, d); chk("R5 R6 order", d, smp_of(e[i % 3]));
    end
  endtask

  task automatic t_empty();
    logic [15:0] d;
    fresh(16'h0001);
    wr(5'h10, 16'h0049);
    convert();
    rd(5'h10, d); chk("R6 one", d, smp_of(8'h49));
    rd(5'h10, d); chk("R7 last value", d, smp_of(8'h49));
    rd(5'h04, d); chk("R7 still empty", d, 16'h0004);
    wr(5'h10, 16'h0083);
    convert(); convert();
    rd(5'h10, d); chk("R7 no underflow", d, smp_of(8'h49));
    rd(5'h10, d); chk("R7 next", d, smp_of(8'h83));
  endtask

  task automatic t_flush();
    logic [15:0] d;
    fresh(16'h0001);
    wr(5'h10, 16'h0021);
    convert(); convert();
    wr(5'h02, 16'h0200); wr(5'h02, 16'h0600);
    rd(5'h04, d); chk("R9 sample flush", d, 16'h0004);
    wr(5'h02, 16'h0400);
    convert(); rd(5'h04, d); chk("R9 list flush", d, 16'h0004);
    wr(5'h10, 16'h0033);
    wr(5'h02, 16'h0600);
    convert(); rd(5'h04, d); chk("R9 list write dropped", d, 16'h0004);
    wr(5'h02, 16'h0200);
    wr(5'h10, 16'h0033);
    convert(); rd(5'h04, d); chk("R9 sample dropped", d, 16'h0004);
  endtask

  task automatic t_listfull();
    logic [15:0] d;
    fresh(16'h0001);
    for (int i = 0; i < 17; i++) wr(5'h10, {8'h0, 8'(i * 17 + 5)});
    rd(5'h04, d); chk("R10 R8 list full", d, 16'h0006);
    for (int i = 0; i < 16; i++) begin
      convert();
      rd(5'h10, d); chk("R10 entry", d, smp_of(8'(i * 17 + 5)));
    end
    convert();
    rd(5'h10, d); chk("R10 wrap after 16", d, smp_of(8'h05));
  endtask

  task automatic t_fill_irq();
    logic [15:0] d;
    fresh(16'h8101);
    wr(5'h10, 16'h003C);
    for (int i = 0; i < 7; i++) convert();
    rd(5'h04, d); chk("R8 seven", d, 16'h0000);
    chk("R12 no irq", {15'b0, irq}, 16'h0);
    convert();
    rd(5'h04, d); chk("R8 R12 half pend", d, 16'h0108);
    idle(2); chk("R12 irq high", {15'b0, irq}, 16'h1);
    wr(5'h04, 16'h0000);
    rd(5'h04, d); chk("R12 cleared", d, 16'h0008);
    idle(2); chk("R12 irq low", {15'b0, irq}, 16'h0);
    for (int i = 0; i < 8; i++) convert();
    rd(5'h04, d); chk("R8 full", d, 16'h0018);
    convert();
    rd(5'h04, d); chk("R11 stays full", d, 16'h0018);
    for (int i = 0; i < 16; i++) begin
      rd(5'h10, d); chk("R11 drain", d, smp_of(8'h3C));
    end
    rd(5'h04, d); chk("R11 exactly 16", d, 16'h0004);
    wr(5'h00, 16'h0101);
    for (int i = 0; i < 8; i++) convert();
    rd(5'h04, d); chk("R12 pend w/o global", d, 16'h0108);
    idle(2); chk("R12 gated", {15'b0, irq}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_format();
    t_ignore();
    t_cycle();
    t_empty();
    t_flush();
    t_listfull();
    t_fill_irq();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule